// File: doc/BRIEF.md
# Shift, Rotate and Bit-Transfer Unit

This unit performs single-position shifts and rotates on a data word. It also moves one bit between a register and the T flag, and sets or clears any single flag of an 8-bit status byte. Each cycle it takes an operand, a bit index, the current status byte and an operation code. One clock edge later it presents the result word and the updated status byte. It sits beside an ALU in a small processor datapath. The register file and the status register live outside the unit, and the caller writes back whichever outputs the operation needs.

Rotates use the carry flag as a ninth bit. The T flag serves as a one-bit scratch cell, so a bit can be copied from one register into another with two operations. There is no multi-position barrel shifting and no storage apart from the output registers.

Top module: `shift_bit_unit`

## Requirements
- R1: While `rst_n` is low, `result` and `status_out` are 0x00.
- R2: Op 0 (shift left) outputs the operand shifted up one place with 0 entering bit 0. C receives the old top bit.
- R3: Op 1 (shift right) outputs the operand shifted down one place with 0 entering the top bit. C receives the old bit 0.
- R4: Op 2 (rotate left) fills bit 0 from C and moves the old top bit into C. Op 3 (rotate right) fills the top bit from C and moves the old bit 0 into C.
- R5: Op 4 (arithmetic right) shifts down one place and keeps the top bit. C receives the old bit 0.
- R6: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. For ops 0 to 4:
  - N is the new top bit.
  - Z is 1 exactly when the result is zero.
  - V is N xor C.
  - S is N xor V.
  - H, T and I keep their input values.
- R7: Op 5 (swap) exchanges the lower and upper halves of the word and leaves the status byte unchanged.
- R8: Op 6 (bit store) copies operand bit `bit_idx` into T and leaves all other status bits and the operand unchanged.
- R9: Op 7 (bit load) writes T into result bit `bit_idx`, leaves the other operand bits unchanged and does not change the status byte.
- R10: Op 8 sets status bit `bit_idx[2:0]` and op 9 clears it. The other status bits keep their values and the result equals the operand.
- R11: Ops 10 to 15 output the operand and the status byte unchanged.
- R12: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 4 | Operation code |
| operand | input | DATA_W | Source word |
| bit_idx | input | $clog2(DATA_W) | Bit index for bit-store, bit-load and flag ops |
| status_in | input | 8 | Current status byte |
| result | output | DATA_W | Registered result word |
| status_out | output | 8 | Registered new status byte |

## Verification
The bench builds the unit with its default DATA_W of 8. At that width the 3-bit index reaches both every bit of the word and every flag of the status byte, so the extreme positions 0 and 7 can be tested for the bit-load, bit-store and flag ops. The chosen operands force a zero result after a shift, carry-in and carry-out on both rotates, and sign retention on the arithmetic shift. The bench also sets the upper flags to check that they survive shift operations.

// File: rtl/shift_bit_unit.sv
module shift_bit_unit #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                op,
  input  logic [DATA_W-1:0]         operand,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic [7:0]                status_in,
  output logic [DATA_W-1:0]         result,
  output logic [7:0]                status_out
);
  localparam int HALF = DATA_W / 2;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FT = 6;

  logic [DATA_W-1:0] res_nx;
  logic [7:0]        st_nx;
  logic              cout;
  logic              is_shift;

  always_comb begin
    res_nx   = operand;
    st_nx    = status_in;
    cout     = status_in[FC];
    is_shift = 1'b0;
    case (op)
      4'd0: begin res_nx = {operand[DATA_W-2:0], 1'b0};           cout = operand[DATA_W-1]; is_shift = 1'b1; end
      4'd1: begin res_nx = {1'b0, operand[DATA_W-1:1]};           cout = operand[0];        is_shift = 1'b1; end
      4'd2: begin res_nx = {operand[DATA_W-2:0], status_in[FC]};  cout = operand[DATA_W-1]; is_shift = 1'b1; end
      4'd3: begin res_nx = {status_in[FC], operand[DATA_W-1:1]};  cout = operand[0];        is_shift = 1'b1; end
      4'd4: begin res_nx = {operand[DATA_W-1], operand[DATA_W-1:1]}; cout = operand[0];     is_shift = 1'b1; end
      4'd5: res_nx = {operand[HALF-1:0], operand[DATA_W-1:HALF]};
      4'd6: st_nx[FT] = operand[bit_idx];
      4'd7: res_nx[bit_idx] = status_in[FT];
      4'd8: st_nx[bit_idx[2:0]] = 1'b1;
      4'd9: st_nx[bit_idx[2:0]] = 1'b0;
      default: ;
    endcase
    if (is_shift) begin
      st_nx[FC] = cout;
      st_nx[FN] = res_nx[DATA_W-1];
      st_nx[FZ] = (res_nx == '0);
      st_nx[FV] = res_nx[DATA_W-1] ^ cout;
      st_nx[FS] = st_nx[FN] ^ st_nx[FV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      status_out <= '0;
    end else begin
      result     <= res_nx;
      status_out <= st_nx;
    end
  end
endmodule

// File: rtl/shift_bit_unit_chk.sv
module shift_bit_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [3:0]                op,
  input logic [DATA_W-1:0]         operand,
  input logic [$clog2(DATA_W)-1:0] bit_idx,
  input logic [7:0]                status_in,
  input logic [DATA_W-1:0]         result,
  input logic [7:0]                status_out
);
  logic                      armed;
  logic [3:0]                p_op;
  logic [DATA_W-1:0]         p_opd;
  logic [$clog2(DATA_W)-1:0] p_idx;
  logic [7:0]                p_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; p_op <= '0; p_opd <= '0; p_idx <= '0; p_st <= '0;
    end else begin
      armed <= 1'b1; p_op <= op; p_opd <= operand; p_idx <= bit_idx; p_st <= status_in;
    end
  end

  logic p_shift;
  assign p_shift = armed && (p_op <= 4'd4);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (result == '0 && status_out == 8'h00));
  a_r6_v_rule: assert property (@(posedge clk) disable iff (!rst_n)
    p_shift |-> status_out[3] == (status_out[2] ^ status_out[0]));
  a_r6_s_rule: assert property (@(posedge clk) disable iff (!rst_n)
    p_shift |-> status_out[4] == (status_out[2] ^ status_out[3]));
  a_r6_z_rule: assert property (@(posedge clk) disable iff (!rst_n)
    p_shift |-> status_out[1] == (result == '0));
  a_r6_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    p_shift |-> status_out[7:5] == p_st[7:5]);
  a_r7_swap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_op == 4'd5) |-> status_out == p_st);
  a_r9_bld_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_op == 4'd7) |-> (result[p_idx] == p_st[6] && status_out == p_st));
  a_r10_flag_result: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (p_op == 4'd8 || p_op == 4'd9)) |-> (result == p_opd && status_out[p_idx[2:0]] == (p_op == 4'd8)));
  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_op >= 4'd10) |-> (result == p_opd && status_out == p_st));
endmodule

bind shift_bit_unit shift_bit_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op(op), .operand(operand), .bit_idx(bit_idx),
  .status_in(status_in), .result(result), .status_out(status_out)
);

// File: tb/shift_bit_unit_tb_top.sv
module shift_bit_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] operand = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] status_in = '0;
  logic [7:0] result, status_out;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_bit_unit #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .operand(operand), .bit_idx(bit_idx),
    .status_in(status_in), .result(result), .status_out(status_out)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic run(string req, logic [3:0] o, logic [7:0] d, logic [2:0] i, logic [7:0] s,
                     logic [7:0] er, logic [7:0] es);
    @(negedge clk);
    op = o; operand = d; bit_idx = i; status_in = s;
    @(negedge clk);
    chk(req, "result", result, er);
    chk(req, "status", status_out, es);
  endtask

  task automatic t_reset;
    @(negedge clk);
    op = 4'd0; operand = 8'hFF; status_in = 8'hFF;
    @(negedge clk);
    chk("R1", "result", result, 8'h00);
    chk("R1", "status", status_out, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic t_shift_left;
    run("R2", 4'd0, 8'h81, 3'd0, 8'h00, 8'h02, 8'h19);
    run("R2", 4'd0, 8'h80, 3'd0, 8'h00, 8'h00, 8'h1B);
  endtask

  task automatic t_shift_right;
    run("R3", 4'd1, 8'h01, 3'd0, 8'hE0, 8'h00, 8'hFB);
  endtask

  task automatic t_rotate;
    run("R4", 4'd2, 8'h40, 3'd0, 8'h01, 8'h81, 8'h0C);
    run("R4", 4'd3, 8'h01, 3'd0, 8'h01, 8'h80, 8'h15);
  endtask

  task automatic t_arith;
    run("R5", 4'd4, 8'h85, 3'd0, 8'h00, 8'hC2, 8'h15);
  endtask

  task automatic t_flags;
    run("R6", 4'd1, 8'h04, 3'd0, 8'hFF, 8'h02, 8'hE0);
  endtask

  task automatic t_swap;
    run("R7", 4'd5, 8'hA5, 3'd0, 8'h3C, 8'h5A, 8'h3C);
  endtask

  task automatic t_bit_store;
    run("R8", 4'd6, 8'h10, 3'd4, 8'h00, 8'h10, 8'h40);
    run("R8", 4'd6, 8'hEF, 3'd4, 8'hFF, 8'hEF, 8'hBF);
  endtask

  task automatic t_bit_load;
    run("R9", 4'd7, 8'h00, 3'd7, 8'h40, 8'h80, 8'h40);
    run("R9", 4'd7, 8'hFF, 3'd0, 8'hBF, 8'hFE, 8'hBF);
  endtask

  task automatic t_flag_ops;
    run("R10", 4'd8, 8'h77, 3'd3, 8'h00, 8'h77, 8'h08);
    run("R10", 4'd9, 8'h33, 3'd7, 8'hFF, 8'h33, 8'h7F);
  endtask

  task automatic t_unused;
    run("R11", 4'd15, 8'h6B, 3'd2, 8'h95, 8'h6B, 8'h95);
    run("R11", 4'd10, 8'h01, 3'd0, 8'h00, 8'h01, 8'h00);
  endtask

  task automatic t_latency;
    @(negedge clk);
    op = 4'd5; operand = 8'h12; status_in = 8'h00;
    @(posedge clk);
    #1;
    op = 4'd5; operand = 8'h34;
    chk("R12", "result", result, 8'h21);
    @(negedge clk);
    chk("R12", "result", result, 8'h21);
    @(posedge clk);
    #1;
    chk("R12", "result", result, 8'h43);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expected=done actual=timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_shift_left();
    t_shift_right();
    t_rotate();
    t_arith();
    t_flags();
    t_swap();
    t_bit_store();
    t_bit_load();
    t_flag_ops();
    t_unused();
    t_latency();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule